// File: doc/BRIEF.md
# Serial Dual-Channel Delay Configuration Loader

This block is the digital control port of a two-channel programmable delay unit. Three slow external wires feed it: a serial clock, a serial data line and a load strobe. The block samples all three into the system clock domain. Each rising serial-clock edge shifts one data bit into an 11-bit frame register. Each rising edge of the load strobe copies the frame's 9-bit delay code into one of two channel holding registers. A channel-select bit inside the frame picks which one.

The same frame also carries a mode bit, and every load latches it. With the mode bit clear, the two delay paths run independently. With it set, the paths are cascaded so that input 0 travels through both channels to output 1, and output 0 is forced inactive. The block reports both delay codes, the mode flag, an enable for output 0 and a routing flag for the cascaded path.

Each channel needs its own frame, so two loads are needed after reset to set both codes. The mode flag always follows the frame loaded most recently, whichever channel that frame targeted.

Top module: `dlyCfgLoader`

## Requirements
- R1: While reset is asserted and after it is released, both delay codes read 0, extendedMode is 0, out0Enable is 1 and route1FromIn0 is 0.
- R2: A frame is 11 bits shifted in first-bit-first. Frame bit 0 (the first bit sent) is the channel select, bit 1 is the mode select, and bits 2 to 10 hold delay code bits D0 to D8, with D8 as the most significant bit. Data is sampled on each rising edge of the serial clock.
- R3: A load whose channel-select bit is 0 writes the frame's 9-bit code into delayCode0.
- R4: A load whose channel-select bit is 1 writes the frame's 9-bit code into delayCode1.
- R5: The channel not selected by a load keeps its previous code.
- R6: Every load sets extendedMode to the frame's mode-select bit, whichever channel the frame targets.
- R7: When extendedMode is 1, out0Enable is 0 (output 0 held inactive) and route1FromIn0 is 1. When extendedMode is 0, out0Enable is 1 and route1FromIn0 is 0.
- R8: Loads happen only on a rising edge of the load strobe. Holding the strobe high while a new frame is shifted in changes nothing.
- R9: Changes on the serial data line without a rising serial-clock edge do not alter the frame.
- R10: Every one of the 512 code values, including 0 and 511, is carried through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock (asynchronous, synchronised inside) |
| serData | input | 1 | Serial frame data |
| loadStrobe | input | 1 | Load strobe; its rising edge commits the frame |
| delayCode0 | output | 9 | Delay code of channel 0 |
| delayCode1 | output | 9 | Delay code of channel 1 |
| extendedMode | output | 1 | 1 = cascaded path, 0 = two independent paths |
| out0Enable | output | 1 | 0 when output 0 is forced to its inactive level |
| route1FromIn0 | output | 1 | 1 when output 1 is fed from input 0 through both channels |

## Verification
The bench builds the block with its default parameters: a 9-bit code, which makes an 11-bit frame, and two synchroniser stages. With these values the extreme codes 0 and 511 can be driven directly, so the most significant bit position of each channel register is exercised. The mode bit is flipped by frames aimed at either channel, so R6 is seen in both directions. The two-stage synchroniser keeps the load latency well inside the bench's serial bit period. The strobe-held-high and data-wiggle sequences can therefore be told apart from genuine edges.

// File: rtl/dlyCfgPkg.sv
package dlyCfgPkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } cfgStrobe_t;
endpackage

// File: rtl/dlySync.sv
module dlySync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stageR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageR <= '0;
    else       stageR <= {stageR[STAGES-2:0], d};
  end

  assign q = stageR[STAGES-1];
endmodule

// File: rtl/dlyCfgCtrl.sv
module dlyCfgCtrl
  import dlyCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       loadStrobe,
  output cfgStrobe_t strobe,
  output logic       dataBit
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncOut;
  logic clkPrev, loadPrev;

  assign rawIn = {loadStrobe, serData, serClk};

  for (genvar i = 0; i < NUM_IN; i++) begin : gSync
    dlySync #(.STAGES(SYNC_STAGES)) syncI (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[i]),
      .q   (syncOut[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= syncOut[0];
      loadPrev <= syncOut[2];
    end
  end

  assign strobe.shiftEn = syncOut[0] & ~clkPrev;
  assign strobe.loadEn  = syncOut[2] & ~loadPrev;
  assign dataBit        = syncOut[1];
endmodule

// File: rtl/dlyCfgDatapath.sv
module dlyCfgDatapath
  import dlyCfgPkg::*;
#(
  parameter int CODE_W  = 9,
  parameter int FRAME_W = CODE_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic               dataBit,
  output logic [FRAME_W-1:0] frameBits,
  output logic [CODE_W-1:0]  delayCode0,
  output logic [CODE_W-1:0]  delayCode1,
  output logic               extendedMode,
  output logic               out0Enable,
  output logic               route1FromIn0
);
  localparam int SEL_POS  = 0;
  localparam int MODE_POS = 1;
  localparam int CODE_LSB = 2;

  logic [FRAME_W-1:0] frameR;
  logic [CODE_W-1:0]  codeR [2];
  logic               modeR;
  logic [CODE_W-1:0]  payload;

  assign payload = frameR[CODE_LSB +: CODE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               frameR <= '0;
    else if (strobe.shiftEn) frameR <= {dataBit, frameR[FRAME_W-1:1]};
  end

  for (genvar ch = 0; ch < 2; ch++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        codeR[ch] <= '0;
      else if (strobe.loadEn && (frameR[SEL_POS] == ch[0]))
        codeR[ch] <= payload;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeR <= 1'b0;
    else if (strobe.loadEn) modeR <= frameR[MODE_POS];
  end

  assign frameBits     = frameR;
  assign delayCode0    = codeR[0];
  assign delayCode1    = codeR[1];
  assign extendedMode  = modeR;
  assign out0Enable    = ~modeR;
  assign route1FromIn0 = modeR;
endmodule

// File: rtl/dlyCfgLoader.sv
module dlyCfgLoader
  import dlyCfgPkg::*;
#(
  parameter int CODE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              loadStrobe,
  output logic [CODE_W-1:0] delayCode0,
  output logic [CODE_W-1:0] delayCode1,
  output logic              extendedMode,
  output logic              out0Enable,
  output logic              route1FromIn0
);
  localparam int FRAME_W = CODE_W + 2;

  cfgStrobe_t         strobe;
  logic               dataBit;
  logic [FRAME_W-1:0] frameBits;

  dlyCfgCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .loadStrobe(loadStrobe),
    .strobe    (strobe),
    .dataBit   (dataBit)
  );

  dlyCfgDatapath #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) dpI (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .dataBit      (dataBit),
    .frameBits    (frameBits),
    .delayCode0   (delayCode0),
    .delayCode1   (delayCode1),
    .extendedMode (extendedMode),
    .out0Enable   (out0Enable),
    .route1FromIn0(route1FromIn0)
  );
endmodule

// File: rtl/dlyCfgChk.sv
module dlyCfgChk
  import dlyCfgPkg::*;
#(
  parameter int CODE_W  = 9,
  parameter int FRAME_W = CODE_W + 2
) (
  input logic               clk,
  input logic               rstN,
  input cfgStrobe_t         strobe,
  input logic               dataBit,
  input logic [FRAME_W-1:0] frameBits,
  input logic [CODE_W-1:0]  delayCode0,
  input logic [CODE_W-1:0]  delayCode1,
  input logic               extendedMode,
  input logic               out0Enable,
  input logic               route1FromIn0
);
  // R2
  frame_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> (frameBits[FRAME_W-2:0] == $past(frameBits[FRAME_W-1:1]))
                       && (frameBits[FRAME_W-1] == $past(dataBit)));

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(frameBits));

  // R3
  load_ch0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && !frameBits[0]) |=> delayCode0 == $past(frameBits[FRAME_W-1:2]));

  // R4
  load_ch1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && frameBits[0]) |=> delayCode1 == $past(frameBits[FRAME_W-1:2]));

  // R5
  keep_ch0_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadEn && !frameBits[0]) |=> $stable(delayCode0));

  // R5
  keep_ch1_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadEn && frameBits[0]) |=> $stable(delayCode1));

  // R6
  mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> extendedMode == $past(frameBits[1]));

  // R7
  out0_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    extendedMode |-> (!out0Enable && route1FromIn0));

  // R7
  out0_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extendedMode |-> (out0Enable && !route1FromIn0));
endmodule

bind dlyCfgLoader dlyCfgChk #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) chkI (
  .clk          (clk),
  .rstN         (rstN),
  .strobe       (strobe),
  .dataBit      (dataBit),
  .frameBits    (frameBits),
  .delayCode0   (delayCode0),
  .delayCode1   (delayCode1),
  .extendedMode (extendedMode),
  .out0Enable   (out0Enable),
  .route1FromIn0(route1FromIn0)
);

// File: tb/dlyCfgLoader_test.sv
`timescale 1ns/1ps
module dlyCfgLoader_test;
  localparam int CODE_W = 9;

  typedef struct {
    logic [CODE_W-1:0] c0;
    logic [CODE_W-1:0] c1;
    logic              mode;
    string             tag;
  } expItem_t;

  logic clk = 0, rstN = 0, serClk = 0, serData = 0, loadStrobe = 0;
  logic [CODE_W-1:0] delayCode0, delayCode1;
  logic extendedMode, out0Enable, route1FromIn0;

  int testsRun = 0, testsFailed = 0;
  expItem_t expQ[$];
  logic [CODE_W-1:0] mc0 = 0, mc1 = 0;
  logic mMode = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dlyCfgLoader #(.CODE_W(CODE_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadStrobe(loadStrobe), .delayCode0(delayCode0), .delayCode1(delayCode1),
    .extendedMode(extendedMode), .out0Enable(out0Enable),
    .route1FromIn0(route1FromIn0)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // bit 0 = channel select, bit 1 = mode, bits 10:2 = code (D0 first)
  task automatic shiftFrame(input logic sel, input logic mode, input logic [CODE_W-1:0] code);
    logic [CODE_W+1:0] f;
    f = {code, mode, sel};
    for (int b = 0; b < CODE_W + 2; b++) begin
      serData = f[b];
      waitClk(3);
      serClk = 1;
      waitClk(6);
      serClk = 0;
      waitClk(3);
    end
  endtask

  task automatic pulseLoad();
    loadStrobe = 1;
    waitClk(6);
    loadStrobe = 0;
    waitClk(6);
  endtask

  task automatic pushExp(input string tag);
    expItem_t it;
    it.c0 = mc0; it.c1 = mc1; it.mode = mMode; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    waitClk(2);
  endtask

  task automatic sendFrame(input logic sel, input logic mode,
                           input logic [CODE_W-1:0] code, input string tag);
    shiftFrame(sel, mode, code);
    pulseLoad();
    if (sel) mc1 = code; else mc0 = code;
    mMode = mode;
    pushExp(tag);
  endtask

  // monitor: pops expected items and compares against outputs
  initial begin
    expItem_t it;
    forever begin
      wait (expQ.size() != 0);
      @(negedge clk);
      it = expQ[0];
      check({it.tag, " code0"}, 32'(delayCode0), 32'(it.c0));
      check({it.tag, " code1"}, 32'(delayCode1), 32'(it.c1));
      check({it.tag, " mode R6"}, 32'(extendedMode), 32'(it.mode));
      check({it.tag, " out0Enable R7"}, 32'(out0Enable), 32'(!it.mode));
      check({it.tag, " route R7"}, 32'(route1FromIn0), 32'(it.mode));
      void'(expQ.pop_front());
    end
  end

  initial begin
    waitClk(150000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    @(negedge clk);
    check("R1 code0 in reset", 32'(delayCode0), 0);
    check("R1 mode in reset", 32'(extendedMode), 0);
    rstN = 1;
    waitClk(3);
    pushExp("R1 after reset");

    sendFrame(0, 0, 9'h0A5, "R3 R2 ch0 load");
    sendFrame(1, 0, 9'h15A, "R4 R5 ch1 load");
    sendFrame(1, 1, 9'h1FF, "R6 R7 R10 ext via ch1 max");
    sendFrame(0, 0, 9'h000, "R6 R10 dual via ch0 zero");
    sendFrame(0, 1, 9'h100, "R6 R7 R2 ext via ch0 msb");
    sendFrame(1, 0, 9'h001, "R2 R4 ch1 lsb");

    // R8: strobe held high while a new frame shifts in
    loadStrobe = 1;
    waitClk(6);
    shiftFrame(0, 1, 9'h0F0);
    pushExp("R8 held strobe no reload");
    loadStrobe = 0;
    waitClk(6);
    pulseLoad();
    mc0 = 9'h0F0; mMode = 1;
    pushExp("R8 fresh edge loads");

    // R9: data wiggles without serial clock edges
    shiftFrame(1, 0, 9'h0C3);
    for (int k = 0; k < 8; k++) begin
      serData = k[0];
      waitClk(4);
    end
    pulseLoad();
    mc1 = 9'h0C3; mMode = 0;
    pushExp("R9 data wiggle ignored");

    for (int n = 0; n < 8; n++) begin
      logic s, m;
      logic [CODE_W-1:0] c;
      s = 1'($urandom);
      m = 1'($urandom);
      c = CODE_W'($urandom);
      sendFrame(s, m, c, s ? "R4 R5 random ch1" : "R3 R5 random ch0");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule